// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out where a single or paired load/store goes in memory and what value, if any, goes back into the base register afterwards. Each request carries a base value, an unsigned offset magnitude with a direction bit, one of three indexing styles (plain offset, update-before-access, update-after-access), an access width, a signedness bit and the three register indices involved. The block checks the encoding against the offset-range and register-pairing rules and raises an illegal flag when any rule is broken.

For loads it also takes the raw data that came back from memory. It extends byte and halfword data to the full word. When a word load targets the program counter, it turns the loaded value into a branch request whose target has bit 0 cleared. If bit 0 of the loaded value is zero, it raises an execution-error flag instead of the branch.

Requests arrive through a valid/ready handshake. Every result appears in a registered response one cycle after the request is accepted, and the response stays stable until the consumer takes it.

Top module: `ldst_agu`

## Requirements
- R1: With `req_mode`=2 (update-after), `rsp_addr` equals the unmodified base, and `rsp_wb_value` equals the base plus the offset (`req_up`=1) or minus the offset (`req_up`=0). `rsp_wb_en` is 1 when the encoding is legal.
- R2: With `req_mode`=1 (update-before), `rsp_addr` and `rsp_wb_value` both equal base±offset, and `rsp_wb_en` is 1 when the encoding is legal.
- R3: With `req_mode`=0 (plain offset), `rsp_addr` is base±offset and `rsp_wb_en` is 0. All address sums wrap modulo 2^32.
- R4: For `req_size` 0 (byte), 1 (halfword) or 2 (word), the offset is illegal when it is subtracted with a magnitude above 255. It is also illegal when it is added with a magnitude above 4095 in mode 0, or above 255 in modes 1 and 2. `req_mode`=3 is always illegal.
- R5: For `req_size`=3 (two words), in every mode, the offset is illegal unless its magnitude is a multiple of 4 and at most 1020.
- R6: `rsp_addr2` equals `rsp_addr` + 4, modulo 2^32.
- R7: A two-word load with `req_rt`==`req_rt2` is illegal. A two-word load in mode 1 or 2 whose `req_rn` equals `req_rt` or `req_rt2` is illegal.
- R8: With index 13 as the stack pointer and index 15 as the program counter, the following are illegal:
  - a load whose `req_rt` is 13 or 15 unless the size is word;
  - a store whose `req_rt` is 13 unless the size is word;
  - a store whose `req_rt` is 15;
  - a store whose `req_rn` is 15.
- R9: `rsp_ld_value` is the low 8 bits (byte) or the low 16 bits (halfword) of `req_ld_data`, sign-extended when `req_signed`=1 and zero-extended otherwise. For word and two-word loads it is `req_ld_data` unchanged, and for stores it is 0.
- R10: For a legal word load with `req_rt`=15:
  - if `req_ld_data[0]`=1, `rsp_branch`=1 and `rsp_branch_target` = `req_ld_data` with bit 0 cleared;
  - if `req_ld_data[0]`=0, `rsp_exec_err`=1 and `rsp_branch`=0.
  In every other case both flags are 0 and the target is 0.
- R11: When `rsp_illegal`=1, `rsp_wb_en`, `rsp_branch` and `rsp_exec_err` are all 0.
- R12: `req_ready` = !`rsp_valid` || `rsp_ready`. A request accepted at a clock edge appears on the response after that edge. While `rsp_valid`=1 and `rsp_ready`=0, the response does not change.
- R13: While and after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_mode | input | 2 | 0 plain offset, 1 update-before, 2 update-after, 3 reserved |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 two words |
| req_signed | input | 1 | Sign-extend byte/halfword load data |
| req_up | input | 1 | 1 add offset, 0 subtract offset |
| req_offset | input | 12 | Offset magnitude |
| req_base | input | 32 | Base register value |
| req_rn | input | 4 | Base register index |
| req_rt | input | 4 | First data register index |
| req_rt2 | input | 4 | Second data register index |
| req_ld_data | input | 32 | Raw data returned by memory for loads |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | First access address |
| rsp_addr2 | output | 32 | Second-word address |
| rsp_wb_en | output | 1 | Write the base register back |
| rsp_wb_value | output | 32 | Updated base value |
| rsp_illegal | output | 1 | Encoding breaks a rule |
| rsp_ld_value | output | 32 | Extended load data |
| rsp_branch | output | 1 | Branch request from a load into the program counter |
| rsp_branch_target | output | 32 | Branch target |
| rsp_exec_err | output | 1 | Loaded program-counter value had bit 0 clear |

## Verification
Base writeback and a branch from a load into the program counter can be requested in the same cycle: a legal word load with `req_rt`=15 in update-before or update-after mode. The register sweep covers every combination of base and destination index, including this one. For each combination, the bench computes on its own whether both `rsp_wb_en` and `rsp_branch` (or `rsp_exec_err`) must be raised together. A second collision is the illegal flag against that pair. The bench pairs a writeback mode with a bad offset or with a forbidden register pairing, and expects the illegal flag to silence both.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned OFF_W  = 12;
    localparam int unsigned RIDX_W = 4;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_PAIR = 2'd3
    } asize_e;

    typedef struct packed {
        word_t addr;
        word_t addr2;
        logic  wb_en;
        word_t wb_value;
        logic  illegal;
        word_t ld_value;
        logic  branch;
        word_t branch_target;
        logic  exec_err;
    } agu_rsp_t;

    function automatic word_t offset_apply(word_t base, off_t mag, logic up);
        word_t ext;
        ext = word_t'(mag);
        return up ? (base + ext) : (base - ext);
    endfunction

    function automatic logic mode_writes_back(amode_e m);
        return (m == AM_PRE) || (m == AM_POST);
    endfunction

    function automatic word_t load_extend(word_t raw, asize_e sz, logic sgn);
        word_t r;
        case (sz)
            SZ_BYTE: r = sgn ? {{(XLEN-8){raw[7]}}, raw[7:0]}
                             : {{(XLEN-8){1'b0}}, raw[7:0]};
            SZ_HALF: r = sgn ? {{(XLEN-16){raw[15]}}, raw[15:0]}
                             : {{(XLEN-16){1'b0}}, raw[15:0]};
            default: r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import ldst_agu_pkg::*;
#(
    parameter int unsigned N_LANES     = 2,
    parameter int unsigned LANE_STRIDE = 4
) (
    input  word_t  base,
    input  off_t   offset,
    input  logic   up,
    input  amode_e mode,
    output word_t  lane_addr [N_LANES],
    output word_t  wb_value,
    output logic   wb_req
);

    word_t moved;
    word_t first;

    assign moved    = offset_apply(base, offset, up);
    assign first    = (mode == AM_POST) ? base : moved;
    assign wb_value = moved;
    assign wb_req   = mode_writes_back(mode);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign lane_addr[i] = first + word_t'(i * LANE_STRIDE);
    end

endmodule

// File: rtl/agu_legality.sv
module agu_legality
    import ldst_agu_pkg::*;
#(
    parameter int unsigned SP_IDX      = 13,
    parameter int unsigned PC_IDX      = 15,
    parameter int unsigned IMM_POS_MAX = 4095,
    parameter int unsigned IDX_MAX     = 255,
    parameter int unsigned NEG_MAX     = 255,
    parameter int unsigned PAIR_MAX    = 1020,
    parameter int unsigned PAIR_ALIGN  = 2
) (
    input  logic   is_load,
    input  amode_e mode,
    input  asize_e size,
    input  logic   up,
    input  off_t   offset,
    input  ridx_t  rn,
    input  ridx_t  rt,
    input  ridx_t  rt2,
    output logic   illegal
);

    localparam int unsigned MW = OFF_W + 1;
    localparam ridx_t SP_R = ridx_t'(SP_IDX);
    localparam ridx_t PC_R = ridx_t'(PC_IDX);

    logic [MW-1:0] mag;
    logic range_bad, regs_bad, mode_bad, wb, special_rt, pair;

    assign mag      = {1'b0, offset};
    assign mode_bad = (mode == AM_RSVD);
    assign wb       = mode_writes_back(mode);
    assign pair     = (size == SZ_PAIR);
    assign special_rt = (rt == SP_R) || (rt == PC_R);

    always_comb begin
        if (pair) begin
            range_bad = (mag > MW'(PAIR_MAX)) || (|offset[PAIR_ALIGN-1:0]);
        end else if (!up) begin
            range_bad = mag > MW'(NEG_MAX);
        end else if (mode == AM_OFFSET) begin
            range_bad = mag > MW'(IMM_POS_MAX);
        end else begin
            range_bad = mag > MW'(IDX_MAX);
        end
    end

    always_comb begin
        if (is_load) begin
            regs_bad = (special_rt && (size != SZ_WORD))
                    || (pair && (rt == rt2))
                    || (pair && wb && ((rn == rt) || (rn == rt2)));
        end else begin
            regs_bad = ((rt == SP_R) && (size != SZ_WORD))
                    || (rt == PC_R)
                    || (rn == PC_R);
        end
    end

    assign illegal = range_bad | regs_bad | mode_bad;

endmodule

// File: rtl/agu_load_path.sv
module agu_load_path
    import ldst_agu_pkg::*;
#(
    parameter int unsigned PC_IDX = 15
) (
    input  logic   is_load,
    input  asize_e size,
    input  logic   sgn,
    input  ridx_t  rt,
    input  word_t  raw,
    input  logic   legal,
    output word_t  ld_value,
    output logic   branch,
    output word_t  branch_target,
    output logic   exec_err
);

    logic pc_word_load;

    assign pc_word_load  = legal && is_load && (size == SZ_WORD) && (rt == ridx_t'(PC_IDX));
    assign ld_value      = is_load ? load_extend(raw, size, sgn) : '0;
    assign branch        = pc_word_load && raw[0];
    assign exec_err      = pc_word_load && !raw[0];
    assign branch_target = branch ? {raw[XLEN-1:1], 1'b0} : '0;

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_agu_pkg::*;
#(
    parameter int unsigned SP_IDX      = 13,
    parameter int unsigned PC_IDX      = 15,
    parameter int unsigned IMM_POS_MAX = 4095,
    parameter int unsigned IDX_MAX     = 255,
    parameter int unsigned NEG_MAX     = 255,
    parameter int unsigned PAIR_MAX    = 1020,
    parameter int unsigned PAIR_ALIGN  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_is_load,
    input  logic [1:0]  req_mode,
    input  logic [1:0]  req_size,
    input  logic        req_signed,
    input  logic        req_up,
    input  logic [11:0] req_offset,
    input  logic [31:0] req_base,
    input  logic [3:0]  req_rn,
    input  logic [3:0]  req_rt,
    input  logic [3:0]  req_rt2,
    input  logic [31:0] req_ld_data,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_addr,
    output logic [31:0] rsp_addr2,
    output logic        rsp_wb_en,
    output logic [31:0] rsp_wb_value,
    output logic        rsp_illegal,
    output logic [31:0] rsp_ld_value,
    output logic        rsp_branch,
    output logic [31:0] rsp_branch_target,
    output logic        rsp_exec_err
);

    localparam int unsigned N_LANES     = 2;
    localparam int unsigned PAIR_STRIDE = XLEN / 8;

    amode_e mode;
    asize_e size;
    assign mode = amode_e'(req_mode);
    assign size = asize_e'(req_size);

    word_t lane_addr [N_LANES];
    word_t wb_value;
    logic  wb_req, illegal;
    word_t ld_value, br_target;
    logic  br, xerr;

    agu_addr_calc #(
        .N_LANES     (N_LANES),
        .LANE_STRIDE (PAIR_STRIDE)
    ) u_addr (
        .base      (req_base),
        .offset    (req_offset),
        .up        (req_up),
        .mode      (mode),
        .lane_addr (lane_addr),
        .wb_value  (wb_value),
        .wb_req    (wb_req)
    );

    agu_legality #(
        .SP_IDX      (SP_IDX),
        .PC_IDX      (PC_IDX),
        .IMM_POS_MAX (IMM_POS_MAX),
        .IDX_MAX     (IDX_MAX),
        .NEG_MAX     (NEG_MAX),
        .PAIR_MAX    (PAIR_MAX),
        .PAIR_ALIGN  (PAIR_ALIGN)
    ) u_legal (
        .is_load (req_is_load),
        .mode    (mode),
        .size    (size),
        .up      (req_up),
        .offset  (req_offset),
        .rn      (req_rn),
        .rt      (req_rt),
        .rt2     (req_rt2),
        .illegal (illegal)
    );

    agu_load_path #(
        .PC_IDX (PC_IDX)
    ) u_load (
        .is_load       (req_is_load),
        .size          (size),
        .sgn           (req_signed),
        .rt            (req_rt),
        .raw           (req_ld_data),
        .legal         (!illegal),
        .ld_value      (ld_value),
        .branch        (br),
        .branch_target (br_target),
        .exec_err      (xerr)
    );

    agu_rsp_t rsp_d, rsp_q;
    logic     valid_q, fire;

    always_comb begin
        rsp_d.addr          = lane_addr[0];
        rsp_d.addr2         = lane_addr[1];
        rsp_d.wb_en         = wb_req && !illegal;
        rsp_d.wb_value      = wb_value;
        rsp_d.illegal       = illegal;
        rsp_d.ld_value      = ld_value;
        rsp_d.branch        = br;
        rsp_d.branch_target = br_target;
        rsp_d.exec_err      = xerr;
    end

    assign req_ready = !valid_q || rsp_ready;
    assign fire      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else if (fire) begin
            valid_q <= 1'b1;
            rsp_q   <= rsp_d;
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rsp_valid         = valid_q;
    assign rsp_addr          = rsp_q.addr;
    assign rsp_addr2         = rsp_q.addr2;
    assign rsp_wb_en         = rsp_q.wb_en;
    assign rsp_wb_value      = rsp_q.wb_value;
    assign rsp_illegal       = rsp_q.illegal;
    assign rsp_ld_value      = rsp_q.ld_value;
    assign rsp_branch        = rsp_q.branch;
    assign rsp_branch_target = rsp_q.branch_target;
    assign rsp_exec_err      = rsp_q.exec_err;

    // R13
    a_r13_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    // R1
    a_r1_post_addr: assert property (@(posedge clk) disable iff (rst)
        (fire && req_mode == AM_POST) |=> rsp_addr == $past(req_base));

    // R2
    a_r2_pre_wb: assert property (@(posedge clk) disable iff (rst)
        (fire && req_mode == AM_PRE) |=>
            (rsp_illegal || (rsp_wb_en && rsp_wb_value == rsp_addr)));

    // R3
    a_r3_offset_no_wb: assert property (@(posedge clk) disable iff (rst)
        (fire && req_mode == AM_OFFSET) |=> !rsp_wb_en);

    // R6
    a_r6_pair_lane: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_addr2 == rsp_addr + PAIR_STRIDE);

    // R10
    a_r10_target_even: assert property (@(posedge clk) disable iff (rst)
        rsp_branch |-> (!rsp_branch_target[0] && !rsp_exec_err));

    // R11
    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_illegal |-> (!rsp_wb_en && !rsp_branch && !rsp_exec_err));

    // R12
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_wb_value) && $stable(rsp_illegal)));

endmodule

// File: tb/ldst_agu_tb_top.sv
module ldst_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_is_load, req_signed, req_up;
    logic [1:0]  req_mode, req_size;
    logic [11:0] req_offset;
    logic [31:0] req_base, req_ld_data;
    logic [3:0]  req_rn, req_rt, req_rt2;
    logic        rsp_valid, rsp_ready, rsp_wb_en, rsp_illegal, rsp_branch, rsp_exec_err;
    logic [31:0] rsp_addr, rsp_addr2, rsp_wb_value, rsp_ld_value, rsp_branch_target;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10ns clk = ~clk;

    ldst_agu dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_is_load (req_is_load), .req_mode (req_mode), .req_size (req_size),
        .req_signed (req_signed), .req_up (req_up), .req_offset (req_offset),
        .req_base (req_base), .req_rn (req_rn), .req_rt (req_rt), .req_rt2 (req_rt2),
        .req_ld_data (req_ld_data),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_addr (rsp_addr), .rsp_addr2 (rsp_addr2),
        .rsp_wb_en (rsp_wb_en), .rsp_wb_value (rsp_wb_value),
        .rsp_illegal (rsp_illegal), .rsp_ld_value (rsp_ld_value),
        .rsp_branch (rsp_branch), .rsp_branch_target (rsp_branch_target),
        .rsp_exec_err (rsp_exec_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected values
    logic [31:0] e_addr, e_addr2, e_wbv, e_ld, e_tgt;
    logic        e_wb, e_ill, e_br, e_err;

    task automatic model();
        logic [31:0] sum;
        logic wbk, pair, pcw;
        int mag;
        mag  = int'(req_offset);
        sum  = req_up ? req_base + {20'd0, req_offset} : req_base - {20'd0, req_offset};
        wbk  = (req_mode == 2'd1) || (req_mode == 2'd2);
        pair = (req_size == 2'd3);
        e_ill = (req_mode == 2'd3);
        if (pair) e_ill |= (mag % 4 != 0) || (mag > 1020);
        else if (!req_up) e_ill |= (mag > 255);
        else if (req_mode == 2'd0) e_ill |= (mag > 4095);
        else e_ill |= (mag > 255);
        if (req_is_load) begin
            if ((req_rt == 4'd13 || req_rt == 4'd15) && req_size != 2'd2) e_ill = 1'b1;
            if (pair && req_rt == req_rt2) e_ill = 1'b1;
            if (pair && wbk && (req_rn == req_rt || req_rn == req_rt2)) e_ill = 1'b1;
        end else begin
            if (req_rt == 4'd13 && req_size != 2'd2) e_ill = 1'b1;
            if (req_rt == 4'd15 || req_rn == 4'd15) e_ill = 1'b1;
        end
        e_addr  = (req_mode == 2'd2) ? req_base : sum;
        e_addr2 = e_addr + 32'd4;
        e_wbv   = sum;
        e_wb    = wbk && !e_ill;
        if (!req_is_load) e_ld = 32'd0;
        else if (req_size == 2'd0) e_ld = req_signed ? 32'(signed'(req_ld_data[7:0])) : {24'd0, req_ld_data[7:0]};
        else if (req_size == 2'd1) e_ld = req_signed ? 32'(signed'(req_ld_data[15:0])) : {16'd0, req_ld_data[15:0]};
        else e_ld = req_ld_data;
        pcw   = !e_ill && req_is_load && req_size == 2'd2 && req_rt == 4'd15;
        e_br  = pcw && req_ld_data[0];
        e_err = pcw && !req_ld_data[0];
        e_tgt = e_br ? (req_ld_data & 32'hFFFF_FFFE) : 32'd0;
    endtask

    // one transaction: drive at negedge, accept at posedge, check at next negedge
    task automatic send();
        @(negedge clk);
        req_valid = 1'b1;
        rsp_ready = 1'b1;
        model();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int offs [11] = '{0, 1, 3, 4, 252, 255, 256, 1020, 1021, 1024, 4095};
        logic [3:0] ridx [4] = '{4'd0, 4'd5, 4'd13, 4'd15};
        logic [31:0] bases [3] = '{32'h0000_0010, 32'hFFFF_FFF8, 32'h8000_1234};
        logic [31:0] datas [3] = '{32'h1234_8F81, 32'hABCD_7F7F, 32'h0000_80FE};
        int t;
        rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b0;
        req_is_load = 0; req_mode = 0; req_size = 0; req_signed = 0; req_up = 0;
        req_offset = 0; req_base = 0; req_rn = 0; req_rt = 0; req_rt2 = 0; req_ld_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rsp_valid, "R13 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        chk(req_ready, "R13 req_ready in reset", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!rsp_valid, "R13 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

        // sweep 1: modes x sizes x direction x offsets x load/store
        t = 0;
        for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
        for (int u = 0; u < 2; u++)
        for (int o = 0; o < 11; o++)
        for (int l = 0; l < 2; l++) begin
            req_mode = 2'(m); req_size = 2'(s); req_up = u[0]; req_offset = 12'(offs[o]);
            req_is_load = l[0]; req_signed = t[1];
            req_base = bases[t % 3]; req_ld_data = datas[t % 3];
            req_rn = 4'd1; req_rt = 4'd2; req_rt2 = 4'd3;
            send();
            chk(rsp_valid, "R12 response one cycle after accept", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_addr == e_addr, (m == 2) ? "R1 address" : (m == 1) ? "R2 address" : "R3 address", rsp_addr, e_addr);
            chk(rsp_addr2 == e_addr2, "R6 second address", rsp_addr2, e_addr2);
            chk(rsp_wb_en == e_wb, (m == 2) ? "R1 wb_en" : (m == 1) ? "R2 wb_en" : "R3 wb_en", {31'd0, rsp_wb_en}, {31'd0, e_wb});
            if (e_wb) chk(rsp_wb_value == e_wbv, (m == 2) ? "R1 wb_value" : "R2 wb_value", rsp_wb_value, e_wbv);
            chk(rsp_illegal == e_ill, (s == 3) ? "R5 pair offset legality" : "R4 single offset legality", {31'd0, rsp_illegal}, {31'd0, e_ill});
            chk(rsp_ld_value == e_ld, "R9 load extension", rsp_ld_value, e_ld);
            t++;
        end

        // sweep 2: register index combinations, collisions of writeback and branch
        t = 0;
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
        for (int l = 0; l < 2; l++)
        for (int s = 1; s < 4; s++)
        for (int m = 0; m < 3; m++) begin
            req_rn = ridx[a]; req_rt = ridx[b]; req_rt2 = ridx[c];
            req_is_load = l[0]; req_size = 2'(s); req_mode = 2'(m);
            req_up = t[0]; req_offset = t[2] ? 12'd8 : 12'd300; req_signed = 1'b0;
            req_base = 32'h0000_4000 + 32'(t); req_ld_data = datas[t % 3];
            send();
            chk(rsp_illegal == e_ill, (s == 3 && l == 1) ? "R7 pairing legality" : "R8 sp/pc legality", {31'd0, rsp_illegal}, {31'd0, e_ill});
            chk(rsp_wb_en == e_wb, "R11 writeback under legality", {31'd0, rsp_wb_en}, {31'd0, e_wb});
            chk(rsp_branch == e_br, "R10 branch", {31'd0, rsp_branch}, {31'd0, e_br});
            chk(rsp_exec_err == e_err, "R10 exec error", {31'd0, rsp_exec_err}, {31'd0, e_err});
            chk(rsp_branch_target == e_tgt, "R10 branch target", rsp_branch_target, e_tgt);
            if (e_ill) chk(!rsp_branch && !rsp_exec_err && !rsp_wb_en, "R11 illegal silences side effects",
                           {29'd0, rsp_branch, rsp_exec_err, rsp_wb_en}, 32'd0);
            t++;
        end

        // backpressure: response held, next request waits
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_is_load = 1'b1; req_mode = 2'd1; req_size = 2'd2;
        req_up = 1'b1; req_offset = 12'd16; req_base = 32'h0000_1000;
        req_rn = 4'd1; req_rt = 4'd2; req_rt2 = 4'd3; req_ld_data = 32'h5;
        @(negedge clk);
        chk(rsp_valid && rsp_addr == 32'h0000_1010, "R12 first response", rsp_addr, 32'h0000_1010);
        chk(!req_ready, "R12 ready low while stalled", {31'd0, req_ready}, 32'd0);
        req_mode = 2'd2; req_base = 32'h0000_2000;
        repeat (2) @(negedge clk);
        chk(rsp_valid && rsp_addr == 32'h0000_1010 && rsp_wb_value == 32'h0000_1010,
            "R12 response stable under stall", rsp_addr, 32'h0000_1010);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_addr == 32'h0000_2000 && rsp_wb_value == 32'h0000_2010,
            "R12 queued request accepted on release", rsp_addr, 32'h0000_2000);
        @(negedge clk);
        chk(!rsp_valid, "R12 response drained", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule